// File: doc/BRIEF.md
# Three-Master Preemptive Bus Arbiter

This block decides which of three masters drives one shared bus. A processor is the lowest priority master. A transfer controller sits in the middle. A FIFO-transfer unit has the highest priority. The processor owns the bus by default and needs no request line. The two higher masters raise a request when they are activated, and they receive a registered grant in return.

A higher-priority request does not always take the bus at once. The arbiter reads status pins from the current owner: whether its bus cycle ends in this clock, whether the boundary that follows falls inside a split longword operation, whether the controller is in a 32-bit transfer, and whether the processor is asleep. From these pins and from the identity of the requester, it decides on which clock edge the owner's grant is withdrawn. Every change of owner leaves one clock with no grant at all. The new owner is then picked by fixed priority from the requests present in that empty clock.

Once the FIFO-transfer unit has the bus, it keeps it until it pulses its completion pin. A master that loses the bus keeps its request high, and it gets the bus again by priority when the higher master is finished.

Top module: `prio_bus_arbiter`

## Requirements
- R1: While `rst_n` is low, and on the first clock after it rises, only `proc_gnt` is high.
- R2: At most one grant is high at any time. A grant that rises must follow a clock in which all three grants were low.
- R3: In a clock with no grant, the next edge grants the FIFO unit if `fifo_req` is high. Otherwise it grants the controller if `xfer_req` is high. Otherwise it grants the processor.
- R4: While the processor owns the bus and is awake, a controller request (with `fifo_req` low) removes `proc_gnt` only on an edge where `proc_cyc_end`=1 and `proc_lw_split`=0.
- R5: While the processor owns the bus and is awake, a FIFO request removes `proc_gnt` on any edge where `proc_cyc_end`=1, including when `proc_lw_split`=1. It never removes it mid-cycle.
- R6: While the processor owns the bus with `proc_sleep`=1, a request from either higher master removes `proc_gnt` on the next edge, whatever the cycle status pins show.
- R7: While the controller owns the bus and keeps `xfer_req` high, a FIFO request removes `xfer_gnt` only on an edge where `xfer_cyc_end`=1, `xfer_lw_split`=0 and `xfer_wide`=0.
- R8: While the FIFO unit owns the bus, `fifo_gnt` stays high until an edge that samples `fifo_done`=1. No other input removes it, and this includes `fifo_req` going low.
- R9: When the controller drops `xfer_req` while it owns the bus, its grant goes low on that edge. If no request is present, `proc_gnt` returns on the next edge.
- R10: A controller that was preempted and kept `xfer_req` high is granted again after the FIFO unit completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| proc_cyc_end | input | 1 | The processor's current bus cycle ends in this clock |
| proc_lw_split | input | 1 | The processor's boundary lies inside a split longword access |
| proc_sleep | input | 1 | The processor is in sleep mode |
| xfer_req | input | 1 | Bus request from the transfer controller |
| xfer_cyc_end | input | 1 | The controller's current bus cycle ends in this clock |
| xfer_lw_split | input | 1 | The controller's boundary lies inside a split longword access |
| xfer_wide | input | 1 | The controller is in a 32-bit transfer, so no boundary may be taken |
| fifo_req | input | 1 | Bus request from the FIFO-transfer unit |
| fifo_done | input | 1 | The FIFO unit's whole operation is complete (pulse) |
| proc_gnt | output | 1 | Bus granted to the processor |
| xfer_gnt | output | 1 | Bus granted to the transfer controller |
| fifo_gnt | output | 1 | Bus granted to the FIFO unit |

## Verification
The hardest case to reach is the controller that holds the bus while the FIFO unit waits. Each hold reason has to be shown on its own: a wide transfer, a split boundary and a cycle that has not ended. After that, a clean boundary has to let the hand-off happen, and the preempted controller, still requesting, has to win the bus back. The stimulus table builds this state step by step. It first moves ownership from the processor to the controller, then holds `fifo_req` high across clocks that each bring up one hold reason. The sleep and split-longword cases for the processor are driven in the same way.

// File: rtl/prio_arb_pkg.sv
package prio_arb_pkg;
  localparam int NUM_MASTERS = 3;
  localparam int OWNER_W = $clog2(NUM_MASTERS + 1);

  // Owner codes: 0 means the bus is in the hand-off gap.
  // Code i+1 stands for the master at grant index i.
  typedef enum logic [OWNER_W-1:0] {
    OWN_GAP  = 0,
    OWN_PROC = 1,
    OWN_XFER = 2,
    OWN_FIFO = 3
  } owner_e;
endpackage

// File: rtl/prio_arb_pick.sv
module prio_arb_pick
  import prio_arb_pkg::*;
(
  input  logic   xfer_req,
  input  logic   fifo_req,
  output owner_e winner
);
  // Fixed priority: FIFO unit first, then controller, then processor.
  always_comb begin
    if (fifo_req)      winner = OWN_FIFO;
    else if (xfer_req) winner = OWN_XFER;
    else               winner = OWN_PROC;
  end
endmodule

// File: rtl/prio_arb_yield.sv
module prio_arb_yield
  import prio_arb_pkg::*;
(
  input  owner_e owner,
  input  logic   proc_cyc_end,
  input  logic   proc_lw_split,
  input  logic   proc_sleep,
  input  logic   xfer_req,
  input  logic   xfer_cyc_end,
  input  logic   xfer_lw_split,
  input  logic   xfer_wide,
  input  logic   fifo_req,
  input  logic   fifo_done,
  output logic   yield
);
  logic proc_yield;
  logic xfer_yield;
  logic xfer_clean_edge;

  // The processor yields to the FIFO unit at any cycle end, even inside a
  // split longword. It yields to the controller only at a full boundary.
  // When it sleeps, it yields at once.
  always_comb begin
    proc_yield = 1'b0;
    if (proc_sleep && (fifo_req || xfer_req)) proc_yield = 1'b1;
    if (fifo_req && proc_cyc_end) proc_yield = 1'b1;
    if (xfer_req && proc_cyc_end && !proc_lw_split) proc_yield = 1'b1;
  end

  assign xfer_clean_edge = xfer_cyc_end && !xfer_lw_split && !xfer_wide;

  // The controller releases the bus when it stops requesting. The FIFO unit
  // may take it only at a boundary that is clean.
  always_comb begin
    xfer_yield = !xfer_req || (fifo_req && xfer_clean_edge);
  end

  always_comb begin
    unique case (owner)
      OWN_PROC: yield = proc_yield;
      OWN_XFER: yield = xfer_yield;
      OWN_FIFO: yield = fifo_done;
      default:  yield = 1'b1;
    endcase
  end
endmodule

// File: rtl/prio_arb_owner.sv
module prio_arb_owner
  import prio_arb_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   yield,
  input  owner_e                 winner,
  input  logic                   proc_cyc_end,
  input  logic                   proc_lw_split,
  input  logic                   proc_sleep,
  input  logic                   xfer_req,
  input  logic                   xfer_cyc_end,
  input  logic                   xfer_lw_split,
  input  logic                   xfer_wide,
  input  logic                   fifo_req,
  input  logic                   fifo_done,
  output owner_e                 owner,
  output logic [NUM_MASTERS-1:0] gnt
);
  owner_e owner_nxt;

  always_comb begin
    if (owner == OWN_GAP) owner_nxt = winner;
    else if (yield)       owner_nxt = OWN_GAP;
    else                  owner_nxt = owner;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) owner <= OWN_PROC;
    else        owner <= owner_nxt;
  end

  // One grant line per master, decoded from the owner code.
  for (genvar i = 0; i < NUM_MASTERS; i++) begin : g_gnt
    assign gnt[i] = (owner == owner_e'(i + 1));
  end

  // R2: grants are exclusive, and each new owner follows an empty clock.
  p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));
  p_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|(gnt & ~$past(gnt))) |-> ($past(gnt) == '0));
  // R3: the gap resolves by priority.
  p_pick_fifo_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt == '0 && fifo_req) |=> gnt[2]);
  p_pick_proc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt == '0 && !fifo_req && !xfer_req) |=> gnt[0]);
  // R4: a controller request cannot split the processor's longword.
  p_proc_split_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt[0] && !proc_sleep && !fifo_req && proc_lw_split) |=> gnt[0]);
  // R5: an awake processor is never cut mid-cycle.
  p_proc_midcyc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt[0] && !proc_sleep && !proc_cyc_end) |=> gnt[0]);
  // R6: a sleeping processor gives up the bus at once.
  p_sleep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt[0] && proc_sleep && (fifo_req || xfer_req)) |=> !gnt[0]);
  // R7: the controller keeps the bus across any boundary that is not clean.
  p_xfer_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt[1] && xfer_req && (xfer_wide || xfer_lw_split || !xfer_cyc_end))
    |=> gnt[1]);
  // R8: the FIFO unit cannot be preempted.
  p_fifo_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt[2] && !fifo_done) |=> gnt[2]);
  // R9: a controller that stops requesting loses its grant.
  p_xfer_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt[1] && !xfer_req) |=> !gnt[1]);
endmodule

// File: rtl/prio_bus_arbiter.sv
module prio_bus_arbiter
  import prio_arb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic proc_cyc_end,
  input  logic proc_lw_split,
  input  logic proc_sleep,
  input  logic xfer_req,
  input  logic xfer_cyc_end,
  input  logic xfer_lw_split,
  input  logic xfer_wide,
  input  logic fifo_req,
  input  logic fifo_done,
  output logic proc_gnt,
  output logic xfer_gnt,
  output logic fifo_gnt
);
  owner_e                 owner;
  owner_e                 winner;
  logic                   yield;
  logic [NUM_MASTERS-1:0] gnt;

  prio_arb_pick u_pick (
    .xfer_req (xfer_req),
    .fifo_req (fifo_req),
    .winner   (winner)
  );

  prio_arb_yield u_yield (
    .owner         (owner),
    .proc_cyc_end  (proc_cyc_end),
    .proc_lw_split (proc_lw_split),
    .proc_sleep    (proc_sleep),
    .xfer_req      (xfer_req),
    .xfer_cyc_end  (xfer_cyc_end),
    .xfer_lw_split (xfer_lw_split),
    .xfer_wide     (xfer_wide),
    .fifo_req      (fifo_req),
    .fifo_done     (fifo_done),
    .yield         (yield)
  );

  prio_arb_owner u_owner (
    .clk           (clk),
    .rst_n         (rst_n),
    .yield         (yield),
    .winner        (winner),
    .proc_cyc_end  (proc_cyc_end),
    .proc_lw_split (proc_lw_split),
    .proc_sleep    (proc_sleep),
    .xfer_req      (xfer_req),
    .xfer_cyc_end  (xfer_cyc_end),
    .xfer_lw_split (xfer_lw_split),
    .xfer_wide     (xfer_wide),
    .fifo_req      (fifo_req),
    .fifo_done     (fifo_done),
    .owner         (owner),
    .gnt           (gnt)
  );

  assign proc_gnt = gnt[0];
  assign xfer_gnt = gnt[1];
  assign fifo_gnt = gnt[2];
endmodule

// File: tb/prio_bus_arbiter_tb_top.sv
module prio_bus_arbiter_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic proc_cyc_end = 0, proc_lw_split = 0, proc_sleep = 0;
  logic xfer_req = 0, xfer_cyc_end = 0, xfer_lw_split = 0, xfer_wide = 0;
  logic fifo_req = 0, fifo_done = 0;
  logic proc_gnt, xfer_gnt, fifo_gnt;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #10 clk = ~clk; // 50 MHz

  prio_bus_arbiter dut_i (
    .clk(clk), .rst_n(rst_n),
    .proc_cyc_end(proc_cyc_end), .proc_lw_split(proc_lw_split),
    .proc_sleep(proc_sleep),
    .xfer_req(xfer_req), .xfer_cyc_end(xfer_cyc_end),
    .xfer_lw_split(xfer_lw_split), .xfer_wide(xfer_wide),
    .fifo_req(fifo_req), .fifo_done(fifo_done),
    .proc_gnt(proc_gnt), .xfer_gnt(xfer_gnt), .fifo_gnt(fifo_gnt)
  );

  // Vector: {tag[3:0], pce psp psl, xrq xce xsp xwd, frq fdn, exp fifo xfer proc}
  localparam int NV = 32;
  localparam logic [15:0] VEC [NV] = '{
    16'b0011_000_0000_00_001, // R3 idle -> processor
    16'b0100_000_1000_00_001, // R4 mid-cycle, hold
    16'b0100_110_1000_00_001, // R4 split boundary, hold
    16'b0100_100_1000_00_000, // R4 clean boundary, release
    16'b0011_000_1000_00_010, // R3 gap -> controller
    16'b0111_000_1101_10_010, // R7 wide transfer, hold
    16'b0111_000_1110_10_010, // R7 split boundary, hold
    16'b0111_000_1000_10_010, // R7 mid-cycle, hold
    16'b0111_000_1100_10_000, // R7 clean boundary, release
    16'b0011_000_1000_10_100, // R3 gap -> FIFO unit wins
    16'b1000_101_1100_10_100, // R8 ignores other pins
    16'b1000_000_1000_00_100, // R8 request dropped, still held
    16'b1000_000_1000_01_000, // R8 done, release
    16'b1010_000_1000_00_010, // R10 controller regains
    16'b1001_000_0000_00_000, // R9 controller drops request
    16'b1001_000_0000_00_001, // R9 processor returns
    16'b0101_010_0000_10_001, // R5 mid-cycle even with split, hold
    16'b0101_110_0000_10_000, // R5 split boundary still released
    16'b0011_000_0000_10_100, // R3 FIFO unit granted
    16'b1000_000_0000_01_000, // R8 done
    16'b1001_000_0000_00_001, // R9 processor returns
    16'b0110_011_1000_00_000, // R6 sleep, controller gets it at once
    16'b0011_000_1000_00_010, // R3 controller
    16'b1001_000_0000_00_000, // R9 drop
    16'b1001_000_0000_00_001, // R9 processor returns
    16'b0110_011_0000_10_000, // R6 sleep, FIFO unit gets it at once
    16'b0011_000_0000_10_100, // R3 FIFO unit
    16'b1000_000_0000_01_000, // R8 done
    16'b1001_000_0000_00_001, // R9 back to processor
    16'b0100_000_0000_00_001, // R4 no request, stays
    16'b0100_110_1000_10_000, // R5 both request at split boundary, FIFO takes it
    16'b0011_000_1000_10_100  // R3 FIFO unit beats controller
  };

  task automatic check_gnt(input logic [2:0] exp, input int tag, input string what);
    logic [2:0] act;
    act = {fifo_gnt, xfer_gnt, proc_gnt};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d %s: actual gnt=%b expected=%b", tag, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    {proc_cyc_end, proc_lw_split, proc_sleep} = '0;
    {xfer_req, xfer_cyc_end, xfer_lw_split, xfer_wide} = '0;
    {fifo_req, fifo_done} = '0;
  endtask

  initial begin
    idle_inputs();
    #25;
    check_gnt(3'b001, 1, "in reset");                 // R1
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #5;
    check_gnt(3'b001, 1, "first clock after reset");  // R1

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {proc_cyc_end, proc_lw_split, proc_sleep} = VEC[i][11:9];
      {xfer_req, xfer_cyc_end, xfer_lw_split, xfer_wide} = VEC[i][8:5];
      {fifo_req, fifo_done} = VEC[i][4:3];
      @(posedge clk); #5;
      check_gnt(VEC[i][2:0], int'(VEC[i][15:12]), $sformatf("vector %0d", i));
      checks++;                                       // R2 exclusivity
      if ($countones({fifo_gnt, xfer_gnt, proc_gnt}) > 1) begin
        fails++;
        $display("FAIL R2 vector %0d: actual gnt=%b expected at most one",
                 i, {fifo_gnt, xfer_gnt, proc_gnt});
      end
    end

    // R1: reset in the middle of FIFO ownership goes back to the processor.
    @(negedge clk) idle_inputs(); fifo_req = 1'b1;
    @(posedge clk); #5;
    check_gnt(3'b100, 3, "FIFO unit before reset");
    @(negedge clk) rst_n = 1'b0;
    #2;
    check_gnt(3'b001, 1, "async reset while FIFO unit owns");
    @(negedge clk) rst_n = 1'b1; fifo_req = 1'b0;
    @(posedge clk); #5;
    check_gnt(3'b001, 1, "after second reset");

    // R8: a long FIFO operation holds for many cycles while others ask.
    @(negedge clk) fifo_req = 1'b1; proc_cyc_end = 1'b1;
    @(posedge clk); #5;
    check_gnt(3'b000, 5, "processor releases to FIFO unit");
    for (int k = 0; k < 10; k++) begin
      @(negedge clk) xfer_req = 1'b1; proc_sleep = k[0];
      @(posedge clk); #5;
      check_gnt(3'b100, 8, "long FIFO hold");
    end
    @(negedge clk) fifo_done = 1'b1; fifo_req = 1'b0;
    @(posedge clk); #5;
    check_gnt(3'b000, 8, "FIFO done gap");
    @(negedge clk) fifo_done = 1'b0;
    @(posedge clk); #5;
    check_gnt(3'b010, 10, "controller regains after long hold");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule